// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a bank of 64 byte-wide registers. Every frame opens with a command byte. Its first bit picks the direction, its second bit picks whether the address steps forward after each byte, and its last six bits name the target register. One or more data bytes follow. All bytes travel most significant bit first. Each frame is bracketed by an active-low chip select.

The serial clock idles high. Input bits are sampled on its rising edge and output bits change on its falling edge. The chip select, clock and data-in lines are resynchronised into the system clock domain, and their edges are detected there. A run-time mode input chooses between two wirings:
- Four-wire: separate data-in and data-out lines.
- Three-wire: one shared line, whose direction the block controls through an output enable.

On the register side the block presents an address, write data, a one-cycle write strobe, and a combinational read-data return.

Top module: `spi_reg_slave`

## Requirements
- R1: Command byte layout, in serial order: bit 0 is the direction (0 = write, 1 = read), bit 1 is the increment flag, and bits 2 to 7 are the register address, MSB first.
- R2: A 16-clock write frame produces exactly one `reg_we_o` pulse, one system clock wide, that carries the commanded address and the data byte assembled MSB first.
- R3: Every further 8 clocks in a frame transfers one more byte. With the increment flag set, the address rises by one after each byte and wraps from 63 to 0.
- R4: With the increment flag clear, every byte of a multi-byte write goes to the commanded address.
- R5: On a read, the register's MSB appears on `sdo_o` from the falling edge that opens serial bit 9. Later bits follow MSB first, one per falling edge, and `sdo_o` changes only after a falling edge.
- R6: Multi-byte reads return consecutive registers (wrapping 63 to 0) when the increment flag is set, and the same register repeatedly when it is clear.
- R7: With `three_wire_i` = 0, `sdo_oe_o` is high throughout a frame and low while chip select is high.
- R8: With `three_wire_i` = 1, `sdo_oe_o` is high only during the data bytes of a read. It stays low during the command byte and throughout write frames.
- R9: Raising chip select part way through a byte discards that byte: no write strobe is issued, and the next frame starts again with a command byte.
- R10: After reset, `reg_we_o` and `sdo_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| three_wire_i | input | 1 | 0: separate in/out lines, 1: shared bidirectional line |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle high |
| sdi_i | input | 1 | Serial data in (the pad input path in three-wire mode) |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |
| reg_addr_o | output | 6 | Register bank address |
| reg_wdata_o | output | 8 | Register bank write data |
| reg_we_o | output | 1 | Register bank write strobe, one cycle |
| reg_rdata_i | input | 8 | Register bank read data for `reg_addr_o` |

## Verification
Writes are tried in three forms: a single byte, an incrementing burst that crosses address 63, and a fixed-address burst. Together these separate correct address stepping and wrap from stuck or wrongly stepped addresses. Reads in the same three forms, checked against the bench's own register model, expose bit-order and first-bit timing faults as well as a wrong address sequence. Frames cut short in the command byte and in the data byte show whether partial bytes leak into the bank or leave the bit counter misaligned. Repeating a read and a write in three-wire mode separates the two output-enable policies.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {PH_CMD, PH_DATA} phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      for (int k = STAGES - 1; k > 0; k--) stg[k] <= stg[k-1];
      stg[0] <= d_i;
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl import spi_reg_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              rd_o,
  output logic              in_data_o,
  output logic              bit_zero_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-2:0] shift_q;
  logic              inc_q, adv_q;
  logic              last_bit;

  assign last_bit = (bit_cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      inc_q     <= 1'b0;
      adv_q     <= 1'b0;
      rd_o      <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
      we_o      <= 1'b0;
    end else if (!cs_act_i) begin
      // frame aborted or idle: realign to a fresh command byte
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      adv_q     <= 1'b0;
      we_o      <= 1'b0;
    end else begin
      we_o  <= 1'b0;
      adv_q <= 1'b0;
      // address steps one cycle after the byte so the strobe sees the old address
      if (adv_q) addr_o <= addr_o + 1'b1;
      if (rise_i) begin
        shift_q   <= {shift_q[DATA_W-3:0], sdi_i};
        bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;
        if (last_bit) begin
          if (phase_q == PH_CMD) begin
            rd_o    <= shift_q[DATA_W-2];
            inc_q   <= shift_q[DATA_W-3];
            addr_o  <= {shift_q[ADDR_W-2:0], sdi_i};
            phase_q <= PH_DATA;
          end else begin
            if (!rd_o) begin
              we_o    <= 1'b1;
              wdata_o <= {shift_q, sdi_i};
            end
            adv_q <= inc_q;
          end
        end
      end
    end
  end

  assign in_data_o  = (phase_q == PH_DATA);
  assign bit_zero_o = (bit_cnt_q == '0);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_q <= '0;
    else if (!cs_act_i) tx_q <= '0;
    else if (fall_i)    tx_q <= load_i ? rdata_i : {tx_q[DATA_W-2:0], 1'b0};
  end

  assign sdo_o = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave import spi_reg_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              three_wire_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic csn_s, sclk_s, sdi_s, sclk_q;
  logic cs_act, sclk_rise, sclk_fall;
  logic rd_mode, in_data, bit_zero;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sclk_i, sdi_i}),
    .q_o   ({csn_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s;
  end

  assign cs_act    = ~csn_s;
  assign sclk_rise = cs_act & sclk_s & ~sclk_q;
  assign sclk_fall = cs_act & ~sclk_s & sclk_q;

  spi_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (cs_act),
    .rise_i    (sclk_rise),
    .sdi_i     (sdi_s),
    .addr_o    (reg_addr_o),
    .wdata_o   (reg_wdata_o),
    .we_o      (reg_we_o),
    .rd_o      (rd_mode),
    .in_data_o (in_data),
    .bit_zero_o(bit_zero)
  );

  spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_act_i(cs_act),
    .fall_i  (sclk_fall),
    .load_i  (in_data & rd_mode & bit_zero),
    .rdata_i (reg_rdata_i),
    .sdo_o   (sdo_o)
  );

  assign sdo_oe_o = cs_act & (three_wire_i ? (in_data & rd_mode) : 1'b1);
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              three_wire_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_we_o,
  input logic              cs_act,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              in_data
);
  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R2

  AST_ADDR_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_act) && $past(in_data) && (reg_addr_o != $past(reg_addr_o)))
    |-> (reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1))); // R3

  AST_SDO_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_act) && !$past(sclk_fall)) |-> $stable(sdo_o)); // R5

  AST_OE3_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (three_wire_i && $rose(sdo_oe_o)) |-> $past(sclk_rise)); // R8

  AST_NO_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act && !$past(cs_act)) |-> !reg_we_o); // R9
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .three_wire_i(three_wire_i),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .reg_addr_o  (reg_addr_o),
  .reg_we_o    (reg_we_o),
  .cs_act      (cs_act),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .in_data     (in_data)
);

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic three_wire = 1'b0, csn = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] bank [64];
  logic [7:0] exp_bank [64];
  logic [13:0] wq [$];
  logic [7:0] txb [4];
  logic [7:0] rxb [4];
  logic cmd_oe_all, cmd_oe_any, dat_oe_all, dat_oe_any;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .three_wire_i(three_wire), .csn_i(csn),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata)
  );

  // register bank environment
  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;
  assign reg_rdata = bank[reg_addr];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wq.size() == 0) begin
        check(1'b0, "R9 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [13:0] e;
        e = wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R2/R3/R4 write", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                          output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0; sdi = tx[i];
      tick(HALF);
      @(negedge clk);
      rx[i] = sdo; oe_all &= sdo_oe; oe_any |= sdo_oe;
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic frame_begin();
    csn = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    csn = 1'b1;
    tick(4 * HALF);
  endtask

  task automatic xfer(input logic rd, input logic inc, input logic [5:0] addr, input int n);
    logic [7:0] dummy;
    logic a, b;
    frame_begin();
    spi_bits({rd, inc, addr}, 8, dummy, cmd_oe_all, cmd_oe_any);
    dat_oe_all = 1'b1; dat_oe_any = 1'b0;
    for (int k = 0; k < n; k++) begin
      spi_bits(txb[k], 8, rxb[k], a, b);
      dat_oe_all &= a; dat_oe_any |= b;
    end
    frame_end();
  endtask

  task automatic do_write(input logic inc, input logic [5:0] addr, input int n);
    logic [5:0] a = addr;
    for (int k = 0; k < n; k++) begin
      wq.push_back({a, txb[k]});
      exp_bank[a] = txb[k];
      if (inc) a = a + 1'b1;
    end
    xfer(1'b0, inc, addr, n);
  endtask

  task automatic do_read(input logic inc, input logic [5:0] addr, input int n, input string req);
    logic [5:0] a = addr;
    for (int k = 0; k < n; k++) txb[k] = 8'h00;
    xfer(1'b1, inc, addr, n);
    for (int k = 0; k < n; k++) begin
      check(rxb[k] == exp_bank[a], req, rxb[k], exp_bank[a]);
      if (inc) a = a + 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      bank[i] = 8'(i * 7 + 3);
      exp_bank[i] = 8'(i * 7 + 3);
    end
    tick(3);
    @(negedge clk);
    check(reg_we == 1'b0, "R10 we after reset", reg_we, 0);
    check(sdo_oe == 1'b0, "R10 oe after reset", sdo_oe, 0);
    rst_n = 1'b1;
    tick(4);
    @(negedge clk);
    check(sdo_oe == 1'b0, "R7 oe idle 4-wire", sdo_oe, 0);

    // R1 R2 single write, four-wire
    txb[0] = 8'hA5;
    do_write(1'b0, 6'd5, 1);
    check(cmd_oe_all && dat_oe_all, "R7 oe in frame 4-wire", {cmd_oe_all, dat_oe_all}, 3);
    @(negedge clk);
    check(sdo_oe == 1'b0, "R7 oe after frame", sdo_oe, 0);

    // R3 incrementing burst with wrap
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33;
    do_write(1'b1, 6'd62, 3);

    // R4 fixed-address burst
    txb[0] = 8'h44; txb[1] = 8'h55; txb[2] = 8'h66;
    do_write(1'b0, 6'd10, 3);

    // R5 single read, R6 bursts
    do_read(1'b0, 6'd5, 1, "R5 single read");
    do_read(1'b1, 6'd62, 3, "R6 incrementing read with wrap");
    do_read(1'b0, 6'd10, 2, "R6 fixed-address read");
    do_read(1'b1, 6'd0, 2, "R1 read low addresses");

    // R9 abort inside data byte
    frame_begin();
    begin
      logic [7:0] r; logic a, b;
      spi_bits({1'b0, 1'b0, 6'd20}, 8, r, a, b);
      spi_bits(8'hFF, 4, r, a, b);
    end
    frame_end();
    do_read(1'b0, 6'd20, 1, "R9 aborted byte not written");

    // R9 abort inside command byte, then a clean frame
    frame_begin();
    begin
      logic [7:0] r; logic a, b;
      spi_bits(8'hC0, 3, r, a, b);
    end
    frame_end();
    txb[0] = 8'h77;
    do_write(1'b0, 6'd21, 1);
    do_read(1'b0, 6'd21, 1, "R9 realigned after abort");

    // R8 three-wire mode
    three_wire = 1'b1;
    tick(2);
    do_read(1'b0, 6'd5, 1, "R8 three-wire read data");
    check(!cmd_oe_any, "R8 oe low in command byte", cmd_oe_any, 0);
    check(dat_oe_all, "R8 oe high in read data", dat_oe_all, 1);
    txb[0] = 8'h3C;
    do_write(1'b0, 6'd30, 1);
    check(!cmd_oe_any && !dat_oe_any, "R8 oe low in write", {cmd_oe_any, dat_oe_any}, 0);
    do_read(1'b1, 6'd30, 1, "R8 three-wire readback");
    @(negedge clk);
    check(sdo_oe == 1'b0, "R8 oe idle three-wire", sdo_oe, 0);

    tick(4);
    check(wq.size() == 0, "R2 all expected writes seen", wq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule